// File: doc/BRIEF.md
# Chroma window key generator

This block marks pixels whose chroma lies inside a programmable rectangle in the UV plane. Each valid pixel carries an unsigned U and V amplitude. Each component is tested against its own lower and upper limit, and the pixel is keyed (alpha = 1) only when both tests pass. The resulting single alpha bit travels next to the RGB data. It becomes the top bit of a 16-bit word beside 5:5:5 RGB, or an extra flag beside 24-bit RGB.

The limits are inclusive and are sampled in the same cycle as the pixel. Programming a component's lower limit above its upper limit leaves no code that can pass that component's test, so keying is switched off. The flag and a matching valid strobe are carried through a register chain of `LATENCY` stages. This keeps them aligned with the output of a colour matrix that runs in parallel.

Top module: `chroma_window_key`

## Requirements
- R1: With `in_valid` high, `key_alpha` is 1 when `u_lo <= u_in <= u_hi` and `v_lo <= v_in <= v_hi`, both bounds inclusive (a window with lo == hi accepts exactly that one code).
- R2: `key_alpha` is 0 for a pixel whose U amplitude is below `u_lo` or above `u_hi`, whatever its V amplitude.
- R3: `key_alpha` is 0 for a pixel whose V amplitude is below `v_lo` or above `v_hi`, whatever its U amplitude.
- R4: When `u_lo > u_hi` or `v_lo > v_hi`, keying is disabled and `key_alpha` is 0 for every pixel.
- R5: `out_valid` repeats `in_valid` exactly `LATENCY` clock edges later (default 3), and `key_alpha` belongs to the same pixel, including for back-to-back pixels and pixels separated by gaps.
- R6: `key_alpha` is 0 whenever `out_valid` is 0, even if the input values during the invalid cycle lie inside both windows.
- R7: While `rst_n` is low, and after its release until the first pixel emerges, `out_valid` and `key_alpha` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present this cycle |
| u_in | input | W | U amplitude, unsigned |
| v_in | input | W | V amplitude, unsigned |
| u_lo | input | W | Lower U limit, inclusive |
| u_hi | input | W | Upper U limit, inclusive |
| v_lo | input | W | Lower V limit, inclusive |
| v_hi | input | W | Upper V limit, inclusive |
| out_valid | output | 1 | Delayed pixel strobe |
| key_alpha | output | 1 | Key flag for the delayed pixel |

## Verification
The bench places pixels exactly on each limit and one code beyond it, for both components. A design using strict comparisons would drop the edge pixels, and a design using the wrong bound would key the outside ones. It programs inverted windows, including pixels whose values fall between the swapped limits. A design that silently swaps the limits would then still key. It streams pixels with gaps and checks each one's arrival cycle and its flag, which exposes an off-by-one stage count or a flag that slips against its strobe. It also checks that in-window data carried with a low valid never raises alpha.

// File: rtl/ckey_pkg.sv
package ckey_pkg;

  // Inclusive window test; an inverted window (lo > hi) admits nothing.
  function automatic logic in_window(input logic [15:0] x,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (lo <= hi) && (x >= lo) && (x <= hi);
  endfunction

endpackage

// File: rtl/ckey_range_cmp.sv
module ckey_range_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] amp,
  input  logic [W-1:0] lim_lo,
  input  logic [W-1:0] lim_hi,
  output logic         hit
);
  import ckey_pkg::*;

  localparam int PAD = 16 - W;

  always_comb begin
    hit = in_window({{PAD{1'b0}}, amp}, {{PAD{1'b0}}, lim_lo}, {{PAD{1'b0}}, lim_hi});
  end

endmodule

// File: rtl/ckey_delay_line.sv
module ckey_delay_line #(
  parameter int DEPTH = 3,
  parameter int DW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] stage [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[i] <= '0;
          else        stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage[DEPTH-1];

endmodule

// File: rtl/chroma_window_key.sv
module chroma_window_key #(
  parameter int W       = 8,
  parameter int LATENCY = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] u_in,
  input  logic [W-1:0] v_in,
  input  logic [W-1:0] u_lo,
  input  logic [W-1:0] u_hi,
  input  logic [W-1:0] v_lo,
  input  logic [W-1:0] v_hi,
  output logic         out_valid,
  output logic         key_alpha
);

  localparam int CNT_W = $clog2(LATENCY + 2) + 1;

  // Named internal events for the assertions
  logic u_hit;
  logic v_hit;
  logic pix_alpha;
  logic [1:0] pipe_in;
  logic [1:0] pipe_out;

  ckey_range_cmp #(.W(W)) u_cmp_u (
    .amp(u_in), .lim_lo(u_lo), .lim_hi(u_hi), .hit(u_hit)
  );

  ckey_range_cmp #(.W(W)) u_cmp_v (
    .amp(v_in), .lim_lo(v_lo), .lim_hi(v_hi), .hit(v_hit)
  );

  assign pix_alpha = in_valid & u_hit & v_hit;
  assign pipe_in   = {in_valid, pix_alpha};

  ckey_delay_line #(.DEPTH(LATENCY), .DW(2)) u_align (
    .clk(clk), .rst_n(rst_n), .din(pipe_in), .dout(pipe_out)
  );

  assign out_valid = pipe_out[1];
  assign key_alpha = pipe_out[0];

  // Pixels in flight: entered minus emerged
  logic [CNT_W-1:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else if (in_valid && !out_valid) inflight <= inflight + 1'b1;
    else if (!in_valid && out_valid) inflight <= inflight - 1'b1;
  end

  // R2: a U amplitude under the lower limit never produces a key
  p_u_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (u_in < u_lo)) |-> !pix_alpha);

  // R3: a V amplitude over the upper limit never produces a key
  p_v_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (v_in > v_hi)) |-> !pix_alpha);

  // R4: inverted window on either component disables keying
  p_inverted_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((u_lo > u_hi) || (v_lo > v_hi)) |-> !pix_alpha);

  // R1: inside both windows with valid gives a key
  p_inside_keys_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && u_lo <= u_in && u_in <= u_hi && v_lo <= v_in && v_in <= v_hi) |-> pix_alpha);

  // R6: flag never set on an empty output slot
  p_alpha_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !key_alpha);

  // R5: no more than LATENCY pixels can be inside the chain
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CNT_W'(LATENCY));

endmodule

// File: tb/chroma_window_key_tb.sv
module chroma_window_key_tb;

  localparam int W   = 8;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] u_in = '0, v_in = '0;
  logic [W-1:0] u_lo = '0, u_hi = '0, v_lo = '0, v_hi = '0;
  logic         out_valid, key_alpha;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;  // 125 MHz

  chroma_window_key #(.W(W), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .u_in(u_in), .v_in(v_in), .u_lo(u_lo), .u_hi(u_hi),
    .v_lo(v_lo), .v_hi(v_hi), .out_valid(out_valid), .key_alpha(key_alpha)
  );

  // Reference: reject if any bound is crossed; an inverted window rejects all
  function automatic logic ref_key(input int u, input int v,
                                   input int ulo, input int uhi,
                                   input int vlo, input int vhi);
    if (ulo > uhi || vlo > vhi) return 1'b0;
    if (u < ulo || u > uhi) return 1'b0;
    if (v < vlo || v > vhi) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic set_win(input int ulo, input int uhi, input int vlo, input int vhi);
    u_lo = W'(ulo); u_hi = W'(uhi); v_lo = W'(vlo); v_hi = W'(vhi);
  endtask

  // Single pixel with idle chain; checks arrival cycle and flag
  task automatic one_pixel(input string req, input int u, input int v);
    logic exp;
    exp = ref_key(u, v, u_lo, u_hi, v_lo, v_hi);
    @(negedge clk);
    in_valid = 1'b1; u_in = W'(u); v_in = W'(v);
    @(posedge clk); #1;
    in_valid = 1'b0;
    for (int j = 1; j < LAT; j++) begin
      check("R5 early", out_valid, 1'b0);
      @(posedge clk); #1;
    end
    check("R5 arrive", out_valid, 1'b1);
    check(req, key_alpha, exp);
  endtask

  task automatic t_reset;
    #1;
    check("R7 valid in reset", out_valid, 1'b0);
    check("R7 alpha in reset", key_alpha, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R7 valid after reset", out_valid, 1'b0);
    check("R7 alpha after reset", key_alpha, 1'b0);
  endtask

  task automatic t_bounds;
    set_win(40, 90, 100, 150);
    one_pixel("R1 centre", 60, 120);
    one_pixel("R1 u_lo edge", 40, 120);
    one_pixel("R1 u_hi edge", 90, 150);
    one_pixel("R1 v_lo edge", 60, 100);
    one_pixel("R2 u below", 39, 120);
    one_pixel("R2 u above", 91, 120);
    one_pixel("R3 v below", 60, 99);
    one_pixel("R3 v above", 60, 151);
    set_win(77, 77, 0, 255);
    one_pixel("R1 single code", 77, 5);
    one_pixel("R2 single code miss", 78, 5);
  endtask

  task automatic t_disable;
    set_win(90, 40, 100, 150);
    one_pixel("R4 u inverted between", 60, 120);
    one_pixel("R4 u inverted on lo", 90, 120);
    set_win(0, 255, 200, 10);
    one_pixel("R4 v inverted", 128, 100);
    one_pixel("R4 v inverted edge", 128, 200);
  endtask

  task automatic t_invalid;
    set_win(0, 255, 0, 255);
    @(negedge clk);
    in_valid = 1'b0; u_in = 8'd50; v_in = 8'd50;
    for (int j = 0; j < LAT + 1; j++) begin
      @(posedge clk); #1;
      check("R6 valid low", out_valid, 1'b0);
      check("R6 alpha low", key_alpha, 1'b0);
    end
  endtask

  task automatic t_stream;
    int   us [8] = '{10, 50, 60, 70, 200, 55, 65, 5};
    int   vs [8] = '{20, 20, 30, 90, 25, 15, 26, 25};
    logic msk [8] = '{1, 1, 0, 1, 1, 1, 0, 1};
    logic ek [8];
    set_win(20, 100, 15, 40);
    for (int k = 0; k < 8; k++)
      ek[k] = msk[k] & ref_key(us[k], vs[k], 20, 100, 15, 40);
    for (int c = 0; c < 8 + LAT; c++) begin
      @(negedge clk);
      if (c < 8) begin
        in_valid = msk[c]; u_in = W'(us[c]); v_in = W'(vs[c]);
      end else begin
        in_valid = 1'b0;
      end
      @(posedge clk); #1;
      if (c - (LAT - 1) >= 0 && c - (LAT - 1) < 8) begin
        check("R5 stream valid", out_valid, msk[c - (LAT - 1)]);
        check("R5 stream alpha", key_alpha, ek[c - (LAT - 1)]);
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_bounds();
    t_disable();
    t_invalid();
    t_stream();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule